// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a multi-channel event timer. It watches a free-running main counter that arrives from outside, together with a strobe that marks each counter advance. When the counter reaches the value held in the channel's comparator, the channel emits a one-cycle expiry pulse. Routing of that pulse to interrupts, status collection and bus address decode all sit outside the block.

The channel runs either once (one-shot) or repeatedly (periodic). In periodic mode a hidden period register sets the spacing between expiries, and the comparator steps forward by that period after each hit. Software loads the comparator and the period through two 32-bit write strobes, one for the low half and one for the high half. A one-time "set value" flag decides whether a write in periodic mode lands in the comparator. The channel can also be narrowed to 32 bits. In that mode a one-shot channel gives an extra expiry when the low half of the counter rolls over.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset, `cmp_o` reads all ones, the hidden period is 0, `expire_o` is 0, and `cfg_rd_o` reads 3'b110. In `cfg_rd_o`, bit 2 is the wide-counter capability (always 1), bit 1 is the periodic capability (always 1) and bit 0 is the pending set-value flag.
- R2: A channel counts as reached when the signed difference counter minus comparator is zero or more. The difference is 32 bits wide in narrow mode and 64 bits otherwise. On a clock edge where `tick_i` is 1 and an armed, enabled channel is reached, `expire_o` is 1 for the single following cycle. Without `tick_i` there is no expiry.
- R3: A comparator that is already behind the counter when the channel is armed fires on the first tick after arming.
- R4: A one-shot channel disarms after its match and gives no further expiry until it is re-armed.
- R5: A comparator write always loads the comparator when `periodic_i` is 0. When `periodic_i` is 1 it loads the comparator only if the set-value flag is 1. Any comparator write clears the set-value flag, which `setval_i` sets.
- R6: In periodic mode a low-half write also loads the low half of the period. A high-half write loads the high half of the period, unless the set-value flag is 1.
- R7: In periodic mode each expiry adds the period to the comparator. After that, the comparator gains one period per clock, with no expiry, until it is ahead of the counter again.
- R8: Period writes keep the period's top bit at 0: bit 31 of a narrow-mode low write, and bit 31 of every high-half write.
- R9: While `mode32_i` is 1, the upper 32 bits of the comparator and of the period are held at 0, so `cmp_o[63:32]` reads 0 one cycle later, even after a high-half write.
- R10: A narrow one-shot channel also expires on a tick where the counter's low 32 bits go from all ones to zero, and it stays armed for the real match.
- R11: A comparator write arms the channel when `glb_en_i` is 1. A rising `ch_en_i` arms it. A rising `glb_en_i` arms it only if the comparator is not all ones.
- R12: No expiry occurs unless both `ch_en_i` and `glb_en_i` were 1. Dropping either one disarms the channel.
- R13: A periodic channel whose period is 0 fires once at the match and then stops, leaving the comparator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 64 | Main counter value |
| tick_i | input | 1 | Counter advanced; evaluate a match this cycle |
| glb_en_i | input | 1 | Global enable |
| ch_en_i | input | 1 | Channel enable |
| periodic_i | input | 1 | 1 = periodic, 0 = one-shot |
| mode32_i | input | 1 | 1 = narrow 32-bit operation |
| setval_i | input | 1 | Pulse that sets the set-value flag |
| wr_lo_i | input | 1 | Write strobe, comparator low half |
| wr_hi_i | input | 1 | Write strobe, comparator high half |
| wr_data_i | input | 32 | Write data |
| expire_o | output | 1 | One-cycle expiry pulse |
| cmp_o | output | 64 | Comparator read-back |
| cfg_rd_o | output | 3 | {wide capability, periodic capability, set-value flag} |

## Verification
The hardest case to reach from the ports is catch-up after missed periods, which needs the counter to jump well past the comparator in one tick. Because the counter is a plain input, the stimulus simply presents a value several periods ahead. It then watches one expiry, followed by a run of clock-by-clock comparator steps with no further pulses. The counter-wrap event needs the narrow one-shot mode and a counter parked just below a 32-bit rollover, which the stimulus sets up directly before stepping across it. A behavioural model in the bench is compared against the design on every clock, and windowed expiry counts check the hand-derived totals.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
    // read-back field positions inside cfg_rd_o
    localparam int unsigned CFGRD_W        = 3;
    localparam int unsigned CFGRD_SETVAL   = 0;
    localparam int unsigned CFGRD_CAP_PER  = 1;
    localparam int unsigned CFGRD_CAP_WIDE = 2;
endpackage

// File: rtl/evt_cmp_reach.sv
module evt_cmp_reach #(
    parameter int unsigned CNT_W = 64
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             narrow_i,
    output logic             reached_o
);
    localparam int unsigned HALF_W = CNT_W / 2;

    logic [CNT_W-1:0]  diff_wide;
    logic [HALF_W-1:0] diff_narrow;

    // sign of counter minus comparator decides behind / reached
    assign diff_wide   = cnt_i - cmp_i;
    assign diff_narrow = cnt_i[HALF_W-1:0] - cmp_i[HALF_W-1:0];
    assign reached_o   = narrow_i ? ~diff_narrow[HALF_W-1] : ~diff_wide[CNT_W-1];
endmodule

// File: rtl/evt_cmp_wrap.sv
module evt_cmp_wrap #(
    parameter int unsigned HALF_W = 32
) (
    input  logic [HALF_W-1:0] prev_lo_i,
    input  logic [HALF_W-1:0] cur_lo_i,
    output logic              wrapped_o
);
    assign wrapped_o = (prev_lo_i == {HALF_W{1'b1}}) && (cur_lo_i == '0);
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evt_cmp_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         cnt_i,
    input  logic                     tick_i,
    input  logic                     glb_en_i,
    input  logic                     ch_en_i,
    input  logic                     periodic_i,
    input  logic                     mode32_i,
    input  logic                     setval_i,
    input  logic                     wr_lo_i,
    input  logic                     wr_hi_i,
    input  logic [CNT_W/2-1:0]       wr_data_i,
    output logic                     expire_o,
    output logic [CNT_W-1:0]         cmp_o,
    output logic [CFGRD_W-1:0]       cfg_rd_o
);
    localparam int unsigned HALF_W = CNT_W / 2;
    localparam logic [HALF_W-1:0] TOP_CLR = {1'b0, {(HALF_W-1){1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0]  cmp;
        logic [CNT_W-1:0]  period;
        logic [HALF_W-1:0] prev_lo;
        logic              setval;
        logic              armed;
        logic              catching;
        logic              en_prev;
        logic              glb_prev;
        logic              expire;
    } chan_t;

    chan_t q, d;

    logic reached;
    logic wrapped;
    logic wr_any;
    logic load_cmp;
    logic fire_ok;
    logic wrap_ev;
    logic [HALF_W-1:0] lo_period;

    evt_cmp_reach #(.CNT_W(CNT_W)) u_reach (
        .cnt_i     (cnt_i),
        .cmp_i     (q.cmp),
        .narrow_i  (mode32_i),
        .reached_o (reached)
    );

    evt_cmp_wrap #(.HALF_W(HALF_W)) u_wrap (
        .prev_lo_i (q.prev_lo),
        .cur_lo_i  (cnt_i[HALF_W-1:0]),
        .wrapped_o (wrapped)
    );

    always_comb begin
        d         = q;
        d.expire  = 1'b0;
        wr_any    = wr_lo_i | wr_hi_i;
        load_cmp  = !periodic_i || q.setval;
        fire_ok   = tick_i && q.armed && ch_en_i && glb_en_i && !q.catching;
        wrap_ev   = mode32_i && !periodic_i && wrapped;
        lo_period = mode32_i ? (wr_data_i & TOP_CLR) : wr_data_i;

        if (tick_i) begin
            d.prev_lo = cnt_i[HALF_W-1:0];
        end

        if (wr_any) begin
            if (wr_lo_i) begin
                if (load_cmp)   d.cmp[HALF_W-1:0]    = wr_data_i;
                if (periodic_i) d.period[HALF_W-1:0] = lo_period;
            end
            if (wr_hi_i) begin
                if (load_cmp) d.cmp[CNT_W-1:HALF_W]    = wr_data_i;
                else          d.period[CNT_W-1:HALF_W] = wr_data_i & TOP_CLR;
            end
            d.setval   = 1'b0;
            d.catching = 1'b0;
            d.armed    = glb_en_i;
        end else begin
            if (setval_i) d.setval = 1'b1;
            if (fire_ok && (reached || wrap_ev)) begin
                d.expire = 1'b1;
                if (reached) begin
                    if (periodic_i && (q.period != '0)) begin
                        d.cmp      = q.cmp + q.period;
                        d.catching = 1'b1;
                    end else begin
                        d.armed = 1'b0;
                    end
                end
            end else if (q.catching) begin
                if (reached && (q.period != '0)) d.cmp = q.cmp + q.period;
                else                              d.catching = 1'b0;
            end
            // enable edges re-arm
            if (!q.en_prev || (!q.glb_prev && (q.cmp != '1))) d.armed = 1'b1;
        end

        if (!ch_en_i || !glb_en_i) begin
            d.armed    = 1'b0;
            d.catching = 1'b0;
        end
        d.en_prev  = ch_en_i;
        d.glb_prev = glb_en_i;

        if (mode32_i) begin
            d.cmp[CNT_W-1:HALF_W]    = '0;
            d.period[CNT_W-1:HALF_W] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cmp      <= '1;
        end else begin
            q <= d;
        end
    end

    assign expire_o                 = q.expire;
    assign cmp_o                    = q.cmp;
    assign cfg_rd_o[CFGRD_SETVAL]   = q.setval;
    assign cfg_rd_o[CFGRD_CAP_PER]  = 1'b1;
    assign cfg_rd_o[CFGRD_CAP_WIDE] = 1'b1;
endmodule

// File: rtl/evt_cmp_channel_chk.sv
module evt_cmp_channel_chk #(
    parameter int unsigned CNT_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input logic               glb_en_i,
    input logic               ch_en_i,
    input logic               periodic_i,
    input logic               mode32_i,
    input logic               wr_lo_i,
    input logic               wr_hi_i,
    input logic               expire_o,
    input logic [CNT_W-1:0]   cmp_o,
    input logic [2:0]         cfg_rd_o
);
    localparam int unsigned HALF_W = CNT_W / 2;

    AST_EXPIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(tick_i)); // R2

    AST_EXPIRE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(ch_en_i && glb_en_i)); // R12

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode32_i)) |-> (cmp_o[CNT_W-1:HALF_W] == '0)); // R9

    AST_SETVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_lo_i || wr_hi_i)) |-> !cfg_rd_o[0]); // R5

    AST_PERIODIC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_lo_i && !wr_hi_i && periodic_i && !cfg_rd_o[0] && !mode32_i))
        |-> (cmp_o == $past(cmp_o))); // R5
endmodule

bind evt_cmp_channel evt_cmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .glb_en_i   (glb_en_i),
    .ch_en_i    (ch_en_i),
    .periodic_i (periodic_i),
    .mode32_i   (mode32_i),
    .wr_lo_i    (wr_lo_i),
    .wr_hi_i    (wr_hi_i),
    .expire_o   (expire_o),
    .cmp_o      (cmp_o),
    .cfg_rd_o   (cfg_rd_o)
);

// File: tb/evt_cmp_channel_tb.sv
module evt_cmp_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt_r = '0;
    logic        tick_r = 0, glb_r = 0, ch_r = 0, per_r = 0, m32_r = 0, sv_r = 0;
    logic        wlo_r = 0, whi_r = 0;
    logic [31:0] wd_r = '0;
    logic        expire_o;
    logic [63:0] cmp_o;
    logic [2:0]  cfg_rd_o;

    always #2 clk = ~clk;

    evt_cmp_channel u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_r), .tick_i(tick_r),
        .glb_en_i(glb_r), .ch_en_i(ch_r), .periodic_i(per_r), .mode32_i(m32_r),
        .setval_i(sv_r), .wr_lo_i(wlo_r), .wr_hi_i(whi_r), .wr_data_i(wd_r),
        .expire_o(expire_o), .cmp_o(cmp_o), .cfg_rd_o(cfg_rd_o)
    );

    int    n_chk = 0, n_fail = 0, exp_cnt = 0, mark = 0;
    bit    done = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference model
    logic [63:0] m_cmp, m_per, dw;
    logic [31:0] m_prev, dn;
    bit m_sv, m_arm, m_catch, m_enp, m_glp, m_exp, hit, wrapev, go, takecmp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cmp = '1; m_per = '0; m_prev = '0;
            m_sv = 0; m_arm = 0; m_catch = 0; m_enp = 0; m_glp = 0; m_exp = 0;
        end else begin
            dw = cnt_r - m_cmp;
            dn = cnt_r[31:0] - m_cmp[31:0];
            hit = m32_r ? !dn[31] : !dw[63];
            wrapev = m32_r && !per_r && (m_prev == 32'hFFFF_FFFF) && (cnt_r[31:0] == 32'h0);
            go = tick_r && m_arm && ch_r && glb_r && !m_catch;
            m_exp = 0;
            if (tick_r) m_prev = cnt_r[31:0];
            if (wlo_r || whi_r) begin
                takecmp = !per_r || m_sv;
                if (wlo_r) begin
                    if (takecmp) m_cmp[31:0] = wd_r;
                    if (per_r) m_per[31:0] = m32_r ? (wd_r & 32'h7FFF_FFFF) : wd_r;
                end
                if (whi_r) begin
                    if (takecmp) m_cmp[63:32] = wd_r;
                    else m_per[63:32] = wd_r & 32'h7FFF_FFFF;
                end
                m_sv = 0; m_catch = 0; m_arm = glb_r;
            end else begin
                if (sv_r) m_sv = 1;
                if (go && (hit || wrapev)) begin
                    m_exp = 1;
                    if (hit && per_r && m_per != 0) begin m_cmp = m_cmp + m_per; m_catch = 1; end
                    else if (hit) m_arm = 0;
                end else if (m_catch) begin
                    if (hit && m_per != 0) m_cmp = m_cmp + m_per;
                    else m_catch = 0;
                end
                if (!m_enp || (!m_glp && m_cmp != '1)) m_arm = 1;
            end
            if (!ch_r || !glb_r) begin m_arm = 0; m_catch = 0; end
            m_enp = ch_r; m_glp = glb_r;
            if (m32_r) begin m_cmp[63:32] = '0; m_per[63:32] = '0; end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(expire_o === m_exp, {cur_req, " expire"}, {63'd0, expire_o}, {63'd0, m_exp});
            chk(cmp_o === m_cmp, {cur_req, " cmp"}, cmp_o, m_cmp);
            chk(cfg_rd_o === {2'b11, m_sv}, {cur_req, " cfg"}, {61'd0, cfg_rd_o}, {61'd0, 2'b11, m_sv});
            if (expire_o) exp_cnt++;
        end
    end

    task automatic tk(input logic [63:0] v);
        @(negedge clk); cnt_r = v; tick_r = 1;
        @(negedge clk); tick_r = 0;
    endtask
    task automatic run(input logic [63:0] a, input logic [63:0] b);
        for (longint unsigned v = a; v <= b; v++) tk(v);
    endtask
    task automatic wlo(input logic [31:0] v);
        @(negedge clk); wlo_r = 1; wd_r = v;
        @(negedge clk); wlo_r = 0;
    endtask
    task automatic whi(input logic [31:0] v);
        @(negedge clk); whi_r = 1; wd_r = v;
        @(negedge clk); whi_r = 0;
    endtask
    task automatic setv();
        @(negedge clk); sv_r = 1;
        @(negedge clk); sv_r = 0;
    endtask
    task automatic settle();
        repeat (3) @(negedge clk);
        @(posedge clk);
    endtask
    task automatic window(input int n, input string req);
        settle();
        chk((exp_cnt - mark) == n, {req, " expiry count"}, 64'(exp_cnt - mark), 64'(n));
        mark = exp_cnt;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); @(posedge clk);
        // R1 reset state
        chk(cmp_o == '1, "R1 cmp reset", cmp_o, '1);
        chk(cfg_rd_o == 3'b110, "R1 cfg reset", {61'd0, cfg_rd_o}, 64'd6);
        chk(expire_o == 0, "R1 expire reset", {63'd0, expire_o}, 64'd0);

        // R2 / R4 one-shot match
        cur_req = "R2";
        wlo(32'd20); whi(32'd0);
        @(negedge clk); ch_r = 1; glb_r = 1;
        mark = exp_cnt;
        run(0, 30);
        window(1, "R2");
        cur_req = "R4";
        run(31, 40);
        window(0, "R4");

        // R3 comparator already behind
        cur_req = "R3";
        wlo(32'd5);
        tk(41);
        window(1, "R3");

        // R5 / R6 periodic write rules
        cur_req = "R5";
        @(negedge clk); per_r = 1;
        wlo(32'd100);
        settle();
        chk(cmp_o == 64'd5, "R5 periodic write without set-value keeps cmp", cmp_o, 64'd5);
        cur_req = "R6";
        whi(32'd5);
        settle();
        chk(cmp_o[63:32] == 0, "R6 high write goes to period", cmp_o, 64'd5);
        whi(32'd0);
        setv();
        settle();
        chk(cfg_rd_o[0] == 1, "R5 set-value flag set", {63'd0, cfg_rd_o[0]}, 64'd1);
        wlo(32'd100);
        settle();
        chk(cfg_rd_o[0] == 0, "R5 set-value self-clears", {63'd0, cfg_rd_o[0]}, 64'd0);
        chk(cmp_o == 64'd100, "R5 set-value write loads cmp", cmp_o, 64'd100);
        cur_req = "R7";
        mark = exp_cnt;
        run(42, 350);
        window(3, "R7");
        chk(cmp_o == 64'd400, "R7 periodic advance", cmp_o, 64'd400);

        // R7 catch-up after a jump
        tk(1000);
        run(1001, 1100);
        window(2, "R7");
        chk(cmp_o == 64'd1200, "R7 catch-up result", cmp_o, 64'd1200);

        // R13 period zero
        cur_req = "R13";
        wlo(32'd0);
        run(1101, 1210);
        window(1, "R13");
        chk(cmp_o == 64'd1200, "R13 cmp unchanged", cmp_o, 64'd1200);

        // R9 narrow mode
        cur_req = "R9";
        @(negedge clk); per_r = 0;
        whi(32'h0000_ABCD);
        settle();
        chk(cmp_o[63:32] == 32'hABCD, "R5 one-shot high write", {32'd0, cmp_o[63:32]}, 64'hABCD);
        @(negedge clk); m32_r = 1;
        settle();
        chk(cmp_o == 64'd1200, "R9 upper cleared", cmp_o, 64'd1200);
        whi(32'h1234);
        settle();
        chk(cmp_o[63:32] == 0, "R9 high write truncated", cmp_o, 64'd1200);

        // R8 period top bit masked (narrow periodic)
        cur_req = "R8";
        @(negedge clk); per_r = 1;
        setv();
        wlo(32'd1300);
        wlo(32'h8000_0010);
        mark = exp_cnt;
        run(1211, 1340);
        window(3, "R8");
        chk(cmp_o == 64'd1348, "R8 masked period step", cmp_o, 64'd1348);

        // R10 wrap event in narrow one-shot
        cur_req = "R10";
        tk(64'hFFFF_FFF0);
        @(negedge clk); per_r = 0;
        wlo(32'h10);
        mark = exp_cnt;
        run(64'hFFFF_FFF1, 64'h1_0000_0020);
        window(2, "R10");

        // R11 global enable re-arm rule
        cur_req = "R11";
        @(negedge clk); m32_r = 0; glb_r = 0;
        wlo(32'hFFFF_FFFF); whi(32'hFFFF_FFFF);
        @(negedge clk); glb_r = 1;
        mark = exp_cnt;
        run(64'h1_0000_0021, 64'h1_0000_0030);
        window(0, "R11");
        @(negedge clk); glb_r = 0;
        wlo(32'h100); whi(32'h1);
        @(negedge clk); glb_r = 1;
        run(64'h1_0000_0031, 64'h1_0000_0110);
        window(1, "R11");

        // R12 channel enable gating
        cur_req = "R12";
        @(negedge clk); ch_r = 0;
        wlo(32'h200);
        run(64'h1_0000_0111, 64'h1_0000_0210);
        window(0, "R12");
        @(negedge clk); ch_r = 1;
        tk(64'h1_0000_0211);
        window(1, "R12");

        done = 1;
        summary();
        $finish;
    end
endmodule